// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Unit

This block is a 32-bit integer add/subtract datapath. It takes two operands, an incoming carry flag and a 2-bit opcode. It produces a result and four condition flags: negative, zero, carry and overflow. It implements plain add, add with carry, plain subtract and subtract with carry.

On subtraction the carry flag means "no borrow": it is set when the subtraction did not need to borrow. Subtract-with-carry takes one extra unit away when the incoming carry is clear.

The arithmetic itself is combinational. It feeds one output register that captures the result and flags whenever an operation is presented with `in_valid_i` high. The register raises `out_valid_o` on the following cycle, so a new operation can be issued every clock.

Top module: `flag_addsub_unit`

## Requirements
- R1: With opcode 00 (add), `result_o` is `a_i + b_i` modulo 2^32, and `c_o` is 1 exactly when that result is unsigned-less than `a_i`.
- R2: With opcode 01 (add with carry) and `carry_i` = 1, `result_o` is `a_i + b_i + 1` and `c_o` is 1 exactly when the result is unsigned-less-or-equal to `a_i`. With `carry_i` = 0 it behaves as opcode 00.
- R3: With opcode 10 (subtract), `result_o` is `a_i - b_i` modulo 2^32, and `c_o` is 1 exactly when `a_i >= b_i` unsigned.
- R4: With opcode 11 (subtract with carry) and `carry_i` = 0, `result_o` is `a_i - b_i - 1` and `c_o` is 1 only when `a_i > b_i` unsigned. With `carry_i` = 1 it behaves as opcode 10.
- R5: `v_o` is bit 31 of `~(a^b) & (a^result)` for opcodes 00 and 01, and bit 31 of `(a^b) & (a^result)` for opcodes 10 and 11.
- R6: `n_o` equals bit 31 of `result_o`, and `z_o` is 1 exactly when `result_o` is zero.
- R7: For opcodes 00 and 10, `carry_i` has no effect on the result or on any flag.
- R8: When `in_valid_i` is high at a rising edge, the result and flags of that operation appear on the outputs and `out_valid_o` is high after that edge. When `in_valid_i` is low, `out_valid_o` is low after the edge and the result and flags keep their previous values.
- R9: While `rst_ni` is low, `out_valid_o`, `result_o` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 subtract with carry |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (subtrahend for subtract) |
| carry_i | input | 1 | Incoming carry flag |
| out_valid_o | output | 1 | Registered outputs hold a fresh result |
| result_o | output | 32 | Registered result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag (no-borrow on subtract) |
| v_o | output | 1 | Signed overflow flag |

## Verification
Two things can happen in the same cycle: one operation's result is presented on the outputs while the next operation is captured. The bench provokes this by issuing operations on consecutive clocks with mixed opcodes and carry values. A scoreboard queue expects exactly one result per cycle and in issue order, so any lost, repeated or late capture shows up as a mismatch.

The bench also inserts idle gaps. After each gap it checks that the held result has not moved and that `out_valid_o` has dropped.

// File: rtl/faddsub_pkg.sv
package faddsub_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBC = 2'b11
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/faddsub_operand.sv
module faddsub_operand
  import faddsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  op_e              op_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] b_eff_o,
  output logic             cin_o
);
  logic is_sub;

  assign is_sub = op_i[1];

  // subtract is a + ~b + 1; with-carry forms take the flag as carry-in
  always_comb begin
    b_eff_o = is_sub ? ~b_i : b_i;
    unique case (op_i)
      OP_ADD:  cin_o = 1'b0;
      OP_SUB:  cin_o = 1'b1;
      default: cin_o = carry_i;
    endcase
  end
endmodule

// File: rtl/faddsub_adder.sv
module faddsub_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int SW = WIDTH + 1;
  logic [SW-1:0] full;

  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{(SW-1){1'b0}}, cin_i};
  assign sum_o  = full[WIDTH-1:0];
  assign cout_o = full[SW-1];
endmodule

// File: rtl/faddsub_flags.sv
module faddsub_flags
  import faddsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_eff_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             cout_i,
  output flags_t           flags_o
);
  localparam int MSB = WIDTH - 1;

  // carry-out of a + b_eff + cin equals the no-borrow carry on subtract
  always_comb begin
    flags_o.n = sum_i[MSB];
    flags_o.z = ~|sum_i;
    flags_o.c = cout_i;
    flags_o.v = ~(a_i[MSB] ^ b_eff_i[MSB]) & (a_i[MSB] ^ sum_i[MSB]);
  end
endmodule

// File: rtl/faddsub_out_reg.sv
module faddsub_out_reg
  import faddsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] sum_i,
  input  flags_t           flags_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] sum_o,
  output flags_t           flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      flags_o <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        sum_o   <= sum_i;
        flags_o <= flags_i;
      end
    end
  end
endmodule

// File: rtl/flag_addsub_unit.sv
module flag_addsub_unit
  import faddsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic             out_valid_o,
  output logic [WIDTH-1:0] result_o,
  output logic             n_o,
  output logic             z_o,
  output logic             c_o,
  output logic             v_o
);
  op_e              op;
  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [WIDTH-1:0] sum;
  logic             cout;
  flags_t           flags_d;
  flags_t           flags_q;

  assign op = op_e'(op_i);

  faddsub_operand #(.WIDTH(WIDTH)) u_operand (
    .op_i    (op),
    .b_i     (b_i),
    .carry_i (carry_i),
    .b_eff_o (b_eff),
    .cin_o   (cin)
  );

  faddsub_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  faddsub_flags #(.WIDTH(WIDTH)) u_flags (
    .a_i     (a_i),
    .b_eff_i (b_eff),
    .sum_i   (sum),
    .cout_i  (cout),
    .flags_o (flags_d)
  );

  faddsub_out_reg #(.WIDTH(WIDTH)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (in_valid_i),
    .sum_i   (sum),
    .flags_i (flags_d),
    .valid_o (out_valid_o),
    .sum_o   (result_o),
    .flags_o (flags_q)
  );

  assign n_o = flags_q.n;
  assign z_o = flags_q.z;
  assign c_o = flags_q.c;
  assign v_o = flags_q.v;
endmodule

// File: rtl/faddsub_checker.sv
module faddsub_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_i,
  input logic             out_valid_o,
  input logic [WIDTH-1:0] result_o,
  input logic             n_o,
  input logic             z_o,
  input logic             c_o,
  input logic             v_o
);
  logic unused_chk;
  assign unused_chk = carry_i;

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o) else $error("AST_VALID_RISE"); // R8
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o) else $error("AST_VALID_DROP"); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(result_o) && $stable({n_o, z_o, c_o, v_o})))
    else $error("AST_HOLD_IDLE"); // R8
  AST_NEG_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (n_o == result_o[WIDTH-1])) else $error("AST_NEG_MSB"); // R6
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (z_o == (result_o == '0))) else $error("AST_ZERO_FLAG"); // R6
  AST_ADD_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 2'b00) |=> (result_o == $past(a_i + b_i)))
    else $error("AST_ADD_SUM"); // R1
  AST_SUB_NOBORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 2'b10) |=> (c_o == $past(a_i >= b_i)))
    else $error("AST_SUB_NOBORROW"); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && result_o == '0)) else $error("AST_RESET_CLEAR"); // R9
endmodule

bind flag_addsub_unit faddsub_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_flag_addsub_unit.sv
`timescale 1ns/1ps
module sim_flag_addsub_unit;
  localparam int W = 32;

  typedef struct packed {
    logic [W-1:0] r;
    logic n, z, c, v;
    logic [1:0] op;
    logic tag7;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] op = 2'b00;
  logic [W-1:0] a = '0, b = '0;
  logic carry = 1'b0;
  logic out_valid, n, z, c, v;
  logic [W-1:0] result;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  flag_addsub_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_i(op),
    .a_i(a), .b_i(b), .carry_i(carry), .out_valid_o(out_valid),
    .result_o(result), .n_o(n), .z_o(z), .c_o(c), .v_o(v)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [1:0] o, input logic [W-1:0] x,
                                 input logic [W-1:0] y, input logic ci);
    exp_t e;
    e = '0;
    e.op = o;
    case (o)
      2'b00: begin e.r = x + y; e.c = (e.r < x); end
      2'b01: if (ci) begin e.r = x + y + 1; e.c = (e.r <= x); end
             else begin e.r = x + y; e.c = (e.r < x); end
      2'b10: begin e.r = x - y; e.c = (x >= y); end
      default: if (!ci) begin e.r = x - y - 1; e.c = (x > y); end
               else begin e.r = x - y; e.c = (x >= y); end
    endcase
    if (o[1]) e.v = ((x ^ y) & (x ^ e.r)) >> (W-1);
    else      e.v = ((~(x ^ y)) & (x ^ e.r)) >> (W-1);
    e.n = e.r[W-1];
    e.z = (e.r == '0);
    return e;
  endfunction

  task automatic issue(input logic [1:0] o, input logic [W-1:0] x,
                       input logic [W-1:0] y, input logic ci);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op = o; a = x; b = y; carry = ci;
    e = model(o, x, y, ci);
    e.tag7 = !o[0];
    q.push_back(e);
  endtask

  task automatic idle(input int n_cyc);
    for (int i = 0; i < n_cyc; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a = $urandom; b = $urandom; op = 2'($urandom); carry = 1'($urandom);
    end
  endtask

  // monitor: one result per issued operation, one cycle after capture
  initial begin
    exp_t e;
    string rt;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (q.size() != 0) begin
          e = q.pop_front();
          chk(out_valid == 1'b1, "R8 out_valid after issue", W'(out_valid), 1);
          case (e.op)
            2'b00: rt = "R1"; 2'b01: rt = "R2"; 2'b10: rt = "R3"; default: rt = "R4";
          endcase
          chk(result == e.r, {rt, " result"}, result, e.r);
          chk(c == e.c, {rt, " carry"}, W'(c), W'(e.c));
          chk(v == e.v, "R5 overflow", W'(v), W'(e.v));
          chk(n == e.n, "R6 negative", W'(n), W'(e.n));
          chk(z == e.z, "R6 zero", W'(z), W'(e.z));
          if (e.tag7)
            chk(result == e.r && c == e.c, "R7 carry_i ignored", result, e.r);
        end else begin
          chk(out_valid == 1'b0, "R8 out_valid idle", W'(out_valid), 0);
        end
      end
    end
  end

  initial begin
    logic [W-1:0] held;
    logic [3:0] hflags;
    #5;
    chk(out_valid == 0 && result == 0, "R9 reset outputs", result, 0);
    chk({n, z, c, v} == 4'b0, "R9 reset flags", W'({n, z, c, v}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // corners
    issue(2'b00, 32'h0, 32'h0, 1'b1);
    issue(2'b00, 32'hFFFF_FFFF, 32'h1, 1'b0);
    issue(2'b00, 32'h7FFF_FFFF, 32'h1, 1'b1);
    issue(2'b01, 32'hFFFF_FFFF, 32'h0, 1'b1);
    issue(2'b01, 32'h5, 32'hFFFF_FFFF, 1'b1);
    issue(2'b01, 32'h5, 32'hFFFF_FFFF, 1'b0);
    issue(2'b10, 32'h5, 32'h5, 1'b0);
    issue(2'b10, 32'h0, 32'h1, 1'b1);
    issue(2'b10, 32'h8000_0000, 32'h1, 1'b0);
    issue(2'b11, 32'h5, 32'h5, 1'b0);
    issue(2'b11, 32'h6, 32'h5, 1'b0);
    issue(2'b11, 32'h5, 32'h5, 1'b1);
    issue(2'b11, 32'h8000_0000, 32'h0, 1'b0);
    idle(1);
    // hold check: outputs unchanged across idle cycles with random inputs
    @(negedge clk);
    held = result; hflags = {n, z, c, v};
    idle(3);
    @(negedge clk);
    chk(result == held && {n, z, c, v} == hflags, "R8 hold while idle", result, held);
    // streamed random back-to-back with gaps
    for (int i = 0; i < 400; i++) begin
      issue(2'($urandom), $urandom, $urandom, 1'($urandom));
      if (i % 37 == 0) idle(2);
    end
    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule